// File: doc/BRIEF.md
# Sector Data Port Buffer

This block is the byte buffer that sits behind the data port of a disk-controller model. The host reads and writes the port 1, 2 or 4 bytes at a time. On a read, the bytes leaving the buffer are assembled into a word. On a write, the word is split into bytes. In both cases a byte-order input decides which end of the word the first byte belongs to. Behind the buffer, a storage back-end fills it one byte at a time, and drains it one byte at a time, through valid/ready handshakes.

The buffer also follows sector boundaries, with a sector being 512 bytes.
- On reads, a completion pulse marks each full sector the host has taken, as long as more data is still waiting.
- On writes, a write command is started with a sector total and a mode. A flush pulse goes out after every sector (single mode), or after every group of sectors (multi mode). Each flush grants the back-end permission to drain exactly that many bytes.
- A remaining-sectors count ends the write once it is used up.
- Sticky flags record reading past empty and writing past full.

Top module: `sector_port_buf`

## Requirements
- R1: A synchronous reset (rst high) leaves the buffer empty and idle:
  - data_req, sector_done, flush_req, overrun, underflow and drain_valid are 0;
  - host_rdata is 0;
  - fill_ready is 1.
- R2: host_size selects the access width: 0 means 1 byte, 1 means 2 bytes, 2 or 3 means 4 bytes. A host read pops that many bytes. A host write during a write command pushes that many bytes. Word lanes above the width read as 0.
- R3: With host_be low, a read puts the first popped byte in bits 7:0, the next in 15:8, then 23:16, then 31:24. host_rdata changes in the cycle after host_rd and holds until the next read.
- R4: With host_be high, a read puts the first popped byte in the most significant lane of the access width, and later bytes in lower lanes.
- R5: A host write pushes its bytes in the same order a read would pop them. With host_be low, bits 7:0 go first. With host_be high, the most significant lane of the width goes first. The back-end drains bytes in push order.
- R6: sector_done pulses for one cycle, in the cycle after a host read that brings the total bytes read since reset to a multiple of 512, provided the buffer still holds data after that read. It does not pulse when that read empties the buffer.
- R7: In single mode (wcmd_multi low), flush_req pulses in the cycle after each host write that completes 512 bytes written since the command started. Each pulse lets the back-end drain 512 more bytes. drain_valid stays low when there is no such allowance.
- R8: In multi mode (wcmd_multi high), flush_req pulses only after 512 × wcmd_group bytes have been written, and the allowance grows by that amount.
- R9: Each flush reduces the remaining sector count by 1 (single mode) or by the group size (multi mode). The write command ends together with the flush that uses up the count. After that, host writes push nothing.
- R10: A host read of more bytes than are buffered returns 0xFF in each missing byte position. It empties the buffer and sets underflow, which stays set until reset.
- R11: Bytes written beyond the 2048-byte capacity are discarded, and overrun is set until reset. The bytes already buffered are kept.
- R12: data_req is high exactly when the buffer holds data or a write command is active.
- R13: fill_ready is low during a write command, when the buffer is full, or in a cycle with host_wr. drain_valid is low in a cycle with host_rd. A fill byte accepted in the same cycle as a host read is kept behind the bytes that read takes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| host_rd | input | 1 | Host read of the data port this cycle |
| host_wr | input | 1 | Host write of the data port this cycle |
| host_size | input | 2 | Access width code (0: 1 byte, 1: 2 bytes, 2/3: 4 bytes) |
| host_be | input | 1 | Byte order: 1 = first byte is most significant |
| host_wdata | input | 32 | Host write word |
| host_rdata | output | 32 | Packed word of the last host read |
| wcmd_start | input | 1 | Start a write command |
| wcmd_multi | input | 1 | Multi-sector group mode for the write command |
| wcmd_sectors | input | SECW | Sectors to be written (0 starts nothing) |
| wcmd_group | input | GRPW | Sectors per flush in multi mode |
| fill_valid | input | 1 | Back-end offers a byte to store |
| fill_data | input | 8 | Byte offered by the back-end |
| fill_ready | output | 1 | Buffer accepts the offered byte |
| drain_valid | output | 1 | A flushed byte is available to the back-end |
| drain_data | output | 8 | Oldest buffered byte |
| drain_ready | input | 1 | Back-end takes the byte |
| data_req | output | 1 | Data transfer pending |
| sector_done | output | 1 | One-cycle pulse: a full sector was read |
| flush_req | output | 1 | One-cycle pulse: a sector or group is ready to drain |
| overrun | output | 1 | Sticky: bytes written past capacity were dropped |
| underflow | output | 1 | Sticky: a read went past the buffered data |

## Verification
A host read can take bytes from the buffer in the same cycle that the back-end fill adds one. In that case the buffer count and the byte order must both come out right. The bench provokes this by raising host_rd and fill_valid on the same edge while four bytes are buffered. It then judges the result at the ports:
- the 4-byte read returns the four older bytes;
- the filled byte is the one the next 1-byte read returns;
- data_req drops afterwards, showing that nothing extra was kept or lost.

It also raises host_wr together with fill_valid, and confirms that fill_ready falls and that the byte is not stored.

// File: rtl/spb_pkg.sv
package spb_pkg;
  localparam int LANES  = 4;
  localparam int WORD_W = 8 * LANES;
  localparam int NB_W   = $clog2(LANES) + 1;
  localparam int LN_W   = $clog2(LANES);

  // access width code -> number of bytes moved
  function automatic logic [NB_W-1:0] spb_nbytes(input logic [1:0] code);
    case (code)
      2'd0:    return NB_W'(1);
      2'd1:    return NB_W'(2);
      default: return NB_W'(4);
    endcase
  endfunction

  // word lane that holds the idx-th byte of an n-byte access
  function automatic logic [LN_W-1:0] spb_lane(input logic [LN_W-1:0] idx,
                                               input logic [NB_W-1:0] n,
                                               input logic be);
    logic [NB_W-1:0] l;
    l = be ? (n - NB_W'(1) - NB_W'(idx)) : NB_W'(idx);
    return l[LN_W-1:0];
  endfunction
endpackage

// File: rtl/spb_lane_xbar.sv
module spb_lane_xbar
  import spb_pkg::*;
(
  input  logic [NB_W-1:0]   nbytes,
  input  logic              be,
  input  logic [WORD_W-1:0] word_in,   // host write word
  input  logic [WORD_W-1:0] seq_in,    // buffered bytes, oldest in lane 0
  output logic [WORD_W-1:0] seq_out,   // write bytes in push order
  output logic [WORD_W-1:0] word_out   // packed read word
);
  // the lane map is its own inverse, so one map serves both directions
  for (genvar i = 0; i < LANES; i++) begin : g_lane
    logic [LN_W-1:0] map;
    logic            live;
    assign map  = spb_lane(LN_W'(i), nbytes, be);
    assign live = (NB_W'(i) < nbytes);
    assign seq_out[8*i +: 8]  = live ? word_in[8*map +: 8] : 8'h00;
    assign word_out[8*i +: 8] = live ? seq_in[8*map +: 8]  : 8'h00;
  end
endmodule

// File: rtl/spb_byte_fifo.sv
module spb_byte_fifo
  import spb_pkg::*;
#(
  parameter int DEPTH = 2048,            // power of two
  localparam int AW   = $clog2(DEPTH),
  localparam int CW   = AW + 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [NB_W-1:0]   push_n,
  input  logic [WORD_W-1:0] push_bytes,
  input  logic [NB_W-1:0]   pop_n,
  output logic [WORD_W-1:0] peek,
  output logic [CW-1:0]     count,
  output logic [CW-1:0]     count_nxt,
  output logic [NB_W-1:0]   pop_act,
  output logic              overrun,
  output logic              underflow
);
  logic [7:0]      mem [DEPTH];
  logic [AW-1:0]   head, tail;
  logic [CW-1:0]   space;
  logic [NB_W-1:0] push_acc;
  logic            ovr_evt, und_evt;

  assign space     = CW'(DEPTH) - count;
  assign push_acc  = (CW'(push_n) > space) ? space[NB_W-1:0] : push_n;
  assign pop_act   = (CW'(pop_n) > count) ? count[NB_W-1:0] : pop_n;
  assign count_nxt = count + CW'(push_acc) - CW'(pop_act);
  assign ovr_evt   = push_n != push_acc;
  assign und_evt   = pop_n != pop_act;

  for (genvar i = 0; i < LANES; i++) begin : g_peek
    logic [AW-1:0] idx;
    assign idx = tail + AW'(i);
    assign peek[8*i +: 8] = (CW'(i) < count) ? mem[idx] : 8'hFF;
  end

  always_ff @(posedge clk) begin
    for (int i = 0; i < LANES; i++)
      if (NB_W'(i) < push_acc) mem[head + AW'(i)] <= push_bytes[8*i +: 8];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      head <= '0; tail <= '0; count <= '0;
      overrun <= 1'b0; underflow <= 1'b0;
    end else begin
      head  <= head + AW'(push_acc);
      tail  <= tail + AW'(pop_act);
      count <= count_nxt;
      if (ovr_evt) overrun <= 1'b1;
      if (und_evt) underflow <= 1'b1;
    end
  end

  // R11
  count_bound_chk: assert property (@(posedge clk) disable iff (rst)
    count <= CW'(DEPTH));
  // R11
  overrun_flag_chk: assert property (@(posedge clk) disable iff (rst)
    (CW'(push_n) > space) |=> overrun);
  // R10
  underflow_flag_chk: assert property (@(posedge clk) disable iff (rst)
    (CW'(pop_n) > count) |=> underflow);
endmodule

// File: rtl/spb_sector_track.sv
module spb_sector_track
  import spb_pkg::*;
#(
  parameter int SECTOR = 512,            // power of two
  parameter int SECW   = 9,
  parameter int GRPW   = 3,
  parameter int CW     = 12
) (
  input  logic            clk,
  input  logic            rst,
  input  logic [NB_W-1:0] rd_pop,
  input  logic [CW-1:0]   cnt_nxt,
  input  logic            wcmd_start,
  input  logic            wcmd_multi,
  input  logic [SECW-1:0] wcmd_sectors,
  input  logic [GRPW-1:0] wcmd_group,
  input  logic [NB_W-1:0] wr_push,
  input  logic            drain_pop,
  output logic            rd_done,
  output logic            wr_flush,
  output logic            wr_busy,
  output logic            credit_avail
);
  localparam int SBW = $clog2(SECTOR);
  localparam int FW  = SBW + GRPW + 1;

  // bytes that make up one flush; a zero group acts as one sector
  function automatic logic [FW-1:0] flush_bytes(input logic multi, input logic [GRPW-1:0] grp);
    logic [GRPW-1:0] g;
    g = (grp == '0) ? GRPW'(1) : grp;
    return multi ? (FW'(SECTOR) * FW'(g)) : FW'(SECTOR);
  endfunction

  function automatic logic [SECW-1:0] flush_step(input logic multi, input logic [GRPW-1:0] grp);
    if (!multi)        return SECW'(1);
    else if (grp == '0) return SECW'(1);
    else               return SECW'(grp);
  endfunction

  logic [SBW-1:0]  rd_pos;
  logic [SBW:0]    rd_sum;
  logic            rd_done_evt;
  logic            multi_q;
  logic [GRPW-1:0] grp_q;
  logic [SECW-1:0] remain, step;
  logic [FW-1:0]   accum, acc_sum, fsz, credit;
  logic            flush_evt;

  assign rd_sum      = {1'b0, rd_pos} + (SBW+1)'(rd_pop);
  assign rd_done_evt = rd_sum[SBW] && (cnt_nxt != '0);
  assign fsz         = flush_bytes(multi_q, grp_q);
  assign step        = flush_step(multi_q, grp_q);
  assign acc_sum     = accum + FW'(wr_push);
  assign flush_evt   = wr_busy && !wcmd_start && (acc_sum >= fsz);
  assign credit_avail = credit != '0;

  always_ff @(posedge clk) begin
    if (rst) begin
      rd_pos <= '0; rd_done <= 1'b0; wr_flush <= 1'b0; wr_busy <= 1'b0;
      remain <= '0; multi_q <= 1'b0; grp_q <= '0; accum <= '0; credit <= '0;
    end else begin
      rd_pos   <= rd_sum[SBW-1:0];
      rd_done  <= rd_done_evt;
      wr_flush <= flush_evt;
      credit   <= credit + (flush_evt ? fsz : '0) - FW'(drain_pop);
      if (wcmd_start) begin
        wr_busy <= wcmd_sectors != '0;
        remain  <= wcmd_sectors;
        multi_q <= wcmd_multi;
        grp_q   <= wcmd_group;
        accum   <= '0;
      end else if (wr_busy) begin
        accum <= flush_evt ? (acc_sum - fsz) : acc_sum;
        if (flush_evt) begin
          if (remain <= step) begin
            remain  <= '0;
            wr_busy <= 1'b0;
          end else begin
            remain <= remain - step;
          end
        end
      end
    end
  end

  // R9
  busy_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (wr_busy && !wcmd_start && !flush_evt) |=> wr_busy);
  // R7
  flush_credit_chk: assert property (@(posedge clk) disable iff (rst)
    wr_flush |-> credit_avail);
endmodule

// File: rtl/sector_port_buf.sv
module sector_port_buf
  import spb_pkg::*;
#(
  parameter int DEPTH  = 2048,
  parameter int SECTOR = 512,
  parameter int SECW   = 9,
  parameter int GRPW   = 3
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            host_rd,
  input  logic            host_wr,
  input  logic [1:0]      host_size,
  input  logic            host_be,
  input  logic [31:0]     host_wdata,
  output logic [31:0]     host_rdata,
  input  logic            wcmd_start,
  input  logic            wcmd_multi,
  input  logic [SECW-1:0] wcmd_sectors,
  input  logic [GRPW-1:0] wcmd_group,
  input  logic            fill_valid,
  input  logic [7:0]      fill_data,
  output logic            fill_ready,
  output logic            drain_valid,
  output logic [7:0]      drain_data,
  input  logic            drain_ready,
  output logic            data_req,
  output logic            sector_done,
  output logic            flush_req,
  output logic            overrun,
  output logic            underflow
);
  localparam int CW = $clog2(DEPTH) + 1;

  logic [NB_W-1:0]   nbytes, push_n, pop_n, pop_act, host_pop;
  logic [WORD_W-1:0] wr_seq, rd_word, peek, push_bytes;
  logic [CW-1:0]     count, count_nxt;
  logic              wr_busy, credit_avail, fill_fire, drain_fire, host_push;

  assign nbytes     = spb_nbytes(host_size);
  assign host_push  = host_wr && wr_busy;
  assign fill_ready = !host_wr && !wr_busy && (count != CW'(DEPTH));
  assign fill_fire  = fill_valid && fill_ready;
  assign drain_valid = !host_rd && credit_avail && (count != '0);
  assign drain_fire = drain_valid && drain_ready;
  assign drain_data = peek[7:0];
  assign push_n     = host_push ? nbytes : (fill_fire ? NB_W'(1) : '0);
  assign push_bytes = host_push ? wr_seq : {{(WORD_W-8){1'b0}}, fill_data};
  assign pop_n      = host_rd ? nbytes : (drain_fire ? NB_W'(1) : '0);
  assign host_pop   = host_rd ? pop_act : '0;
  assign data_req   = (count != '0) || wr_busy;

  spb_lane_xbar u_xbar (
    .nbytes(nbytes), .be(host_be), .word_in(host_wdata), .seq_in(peek),
    .seq_out(wr_seq), .word_out(rd_word)
  );

  spb_byte_fifo #(.DEPTH(DEPTH)) u_fifo (
    .clk(clk), .rst(rst), .push_n(push_n), .push_bytes(push_bytes),
    .pop_n(pop_n), .peek(peek), .count(count), .count_nxt(count_nxt),
    .pop_act(pop_act), .overrun(overrun), .underflow(underflow)
  );

  spb_sector_track #(.SECTOR(SECTOR), .SECW(SECW), .GRPW(GRPW), .CW(CW)) u_track (
    .clk(clk), .rst(rst), .rd_pop(host_pop), .cnt_nxt(count_nxt),
    .wcmd_start(wcmd_start), .wcmd_multi(wcmd_multi), .wcmd_sectors(wcmd_sectors),
    .wcmd_group(wcmd_group), .wr_push(host_push ? nbytes : NB_W'(0)),
    .drain_pop(drain_fire), .rd_done(sector_done), .wr_flush(flush_req),
    .wr_busy(wr_busy), .credit_avail(credit_avail)
  );

  always_ff @(posedge clk) begin
    if (rst)          host_rdata <= '0;
    else if (host_rd) host_rdata <= rd_word;
  end

  // R6
  rd_done_src_chk: assert property (@(posedge clk) disable iff (rst)
    sector_done |-> $past(host_rd));
  // R13
  fill_drq_chk: assert property (@(posedge clk) disable iff (rst)
    (fill_valid && fill_ready) |=> data_req);
endmodule

// File: tb/sector_port_buf_tb.sv
module sector_port_buf_tb;
  logic clk = 1'b0;
  logic rst;
  logic host_rd, host_wr, host_be;
  logic [1:0] host_size;
  logic [31:0] host_wdata, host_rdata;
  logic wcmd_start, wcmd_multi;
  logic [8:0] wcmd_sectors;
  logic [2:0] wcmd_group;
  logic fill_valid, fill_ready, drain_valid, drain_ready;
  logic [7:0] fill_data, drain_data;
  logic data_req, sector_done, flush_req, overrun, underflow;

  int checks = 0;
  int errors = 0;
  int cycles = 0;
  bit finished = 1'b0;

  always #5 clk = ~clk;

  sector_port_buf u_dut (
    .clk(clk), .rst(rst), .host_rd(host_rd), .host_wr(host_wr), .host_size(host_size),
    .host_be(host_be), .host_wdata(host_wdata), .host_rdata(host_rdata),
    .wcmd_start(wcmd_start), .wcmd_multi(wcmd_multi), .wcmd_sectors(wcmd_sectors),
    .wcmd_group(wcmd_group), .fill_valid(fill_valid), .fill_data(fill_data),
    .fill_ready(fill_ready), .drain_valid(drain_valid), .drain_data(drain_data),
    .drain_ready(drain_ready), .data_req(data_req), .sector_done(sector_done),
    .flush_req(flush_req), .overrun(overrun), .underflow(underflow)
  );

  always @(posedge clk) begin
    cycles <= cycles + 1;
    if (cycles == 150000 && !finished) begin
      errors = errors + 1;
      $display("FAIL watchdog actual %0d expected done", cycles);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst = 1'b1; host_rd = 0; host_wr = 0; host_be = 0; host_size = 0; host_wdata = 0;
    wcmd_start = 0; wcmd_multi = 0; wcmd_sectors = 0; wcmd_group = 0;
    fill_valid = 0; fill_data = 0; drain_ready = 0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
  endtask

  task automatic fill_byte(input logic [7:0] d);
    @(negedge clk); fill_valid = 1'b1; fill_data = d;
    @(negedge clk); fill_valid = 1'b0;
  endtask

  task automatic host_read(input logic [1:0] sz, input logic be);
    @(negedge clk); host_rd = 1'b1; host_size = sz; host_be = be;
    @(negedge clk); host_rd = 1'b0;
  endtask

  task automatic host_write(input logic [1:0] sz, input logic be, input logic [31:0] w);
    @(negedge clk); host_wr = 1'b1; host_size = sz; host_be = be; host_wdata = w;
    @(negedge clk); host_wr = 1'b0;
  endtask

  task automatic start_write(input int secs, input logic multi, input int grp);
    @(negedge clk); wcmd_start = 1'b1; wcmd_sectors = 9'(secs); wcmd_multi = multi;
    wcmd_group = 3'(grp);
    @(negedge clk); wcmd_start = 1'b0;
  endtask

  // drains n bytes; returns how many were missing or differed from f(k)
  task automatic drain_seq(input int n, input int base, input int mulk, output int bad);
    bad = 0;
    for (int k = 0; k < n; k++) begin
      @(negedge clk);
      if (!drain_valid || drain_data !== 8'((base + k) * mulk)) bad++;
      drain_ready = 1'b1;
      @(negedge clk);
      drain_ready = 1'b0;
    end
  endtask

  task automatic t_reset();
    do_reset();
    chk("R1 data_req", data_req, 0);
    chk("R1 flags", {sector_done, flush_req, overrun, underflow, drain_valid}, 0);
    chk("R1 rdata", host_rdata, 0);
    chk("R1 fill_ready", fill_ready, 1);
  endtask

  task automatic t_pack();
    do_reset();
    for (int i = 0; i < 16; i++) fill_byte(8'(8'h10 + i));
    chk("R12 data_req with data", data_req, 1);
    host_read(2'd1, 1'b0);
    chk("R2/R3 2-byte little", host_rdata, 32'h0000_1110);
    host_read(2'd2, 1'b1);
    chk("R4 4-byte big", host_rdata, 32'h1213_1415);
    host_read(2'd0, 1'b1);
    chk("R2 1-byte", host_rdata, 32'h0000_0016);
    host_read(2'd2, 1'b0);
    chk("R3 4-byte little", host_rdata, 32'h1A19_1817);
    host_read(2'd3, 1'b1);
    chk("R2/R4 code 3 is 4 bytes", host_rdata, 32'h1B1C_1D1E);
    chk("R10 no underflow yet", underflow, 0);
    host_read(2'd2, 1'b0);
    chk("R10 partial read", host_rdata, 32'hFFFF_FF1F);
    chk("R10 underflow set", underflow, 1);
    chk("R12 empty idle", data_req, 0);
    repeat (3) @(negedge clk);
    chk("R3 rdata held", host_rdata, 32'hFFFF_FF1F);
    chk("R10 underflow sticky", underflow, 1);
  endtask

  task automatic t_same_cycle();
    do_reset();
    for (int i = 0; i < 4; i++) fill_byte(8'(8'hA0 + i));
    @(negedge clk);
    host_rd = 1'b1; host_size = 2'd2; host_be = 1'b0;
    fill_valid = 1'b1; fill_data = 8'hB0;
    #1 chk("R13 fill_ready during host read", fill_ready, 1);
    chk("R13 drain_valid low on host read", drain_valid, 0);
    @(negedge clk); host_rd = 1'b0; fill_valid = 1'b0;
    chk("R13 concurrent read word", host_rdata, 32'hA3A2_A1A0);
    host_read(2'd0, 1'b0);
    chk("R13 concurrent fill kept", host_rdata, 32'h0000_00B0);
    chk("R12 empty after", data_req, 0);
    chk("R10 no underflow", underflow, 0);
  endtask

  task automatic t_read_sector();
    int pulses, at;
    do_reset();
    for (int i = 0; i < 1024; i++) fill_byte(8'(i));
    pulses = 0; at = -1;
    for (int k = 0; k < 256; k++) begin
      host_read(2'd2, 1'b0);
      if (k == 0) chk("R3 first word", host_rdata, 32'h0302_0100);
      if (sector_done) begin pulses++; at = k; end
    end
    chk("R6 one pulse", 32'(pulses), 1);
    chk("R6 pulse at 512 bytes", 32'(at), 127);
    chk("R6 last read word", host_rdata, 32'hFFFE_FDFC);
  endtask

  task automatic t_write_single();
    int flushes, at, bad;
    do_reset();
    start_write(2, 1'b0, 0);
    chk("R12 busy raises data_req", data_req, 1);
    chk("R13 fill_ready low while busy", fill_ready, 0);
    flushes = 0; at = -1;
    for (int k = 0; k < 128; k++) begin
      host_write(2'd2, 1'b0, {8'(4*k+3), 8'(4*k+2), 8'(4*k+1), 8'(4*k)});
      if (k == 0) chk("R7 no drain before flush", drain_valid, 0);
      if (flush_req) begin flushes++; at = k; end
    end
    chk("R7 single flush count", 32'(flushes), 1);
    chk("R7 flush at 512", 32'(at), 127);
    drain_seq(512, 0, 1, bad);
    chk("R5 little drain order", 32'(bad), 0);
    chk("R7 allowance used", drain_valid, 0);
    flushes = 0; at = -1;
    for (int k = 0; k < 256; k++) begin
      host_write(2'd1, 1'b1, {16'h0, 8'(6*k), 8'(6*k+3)});
      if (flush_req) begin flushes++; at = k; end
    end
    chk("R7 second flush", 32'(at), 255);
    drain_seq(512, 0, 3, bad);
    chk("R5 big drain order", 32'(bad), 0);
    chk("R9/R12 write ended", data_req, 0);
    host_write(2'd2, 1'b0, 32'h1234_5678);
    chk("R9 write ignored after end", data_req, 0);
    @(negedge clk); host_wr = 1'b1; fill_valid = 1'b1; fill_data = 8'h55;
    #1 chk("R13 fill_ready low on host_wr", fill_ready, 0);
    @(negedge clk); host_wr = 1'b0; fill_valid = 1'b0;
    chk("R13 byte not stored", data_req, 0);
  endtask

  task automatic t_write_multi();
    int flushes, at, bad;
    do_reset();
    start_write(4, 1'b1, 2);
    flushes = 0; at = -1;
    for (int k = 0; k < 256; k++) begin
      host_write(2'd2, 1'b0, {8'(4*k+3), 8'(4*k+2), 8'(4*k+1), 8'(4*k)});
      if (flush_req) begin flushes++; at = k; end
    end
    chk("R8 one flush per group", 32'(flushes), 1);
    chk("R8 flush at 1024", 32'(at), 255);
    drain_seq(1024, 0, 1, bad);
    chk("R8 group drained", 32'(bad), 0);
    chk("R9 still busy after first group", data_req, 1);
    for (int k = 0; k < 256; k++)
      host_write(2'd2, 1'b0, {8'(4*k+3), 8'(4*k+2), 8'(4*k+1), 8'(4*k)});
    chk("R8 second group flushed", drain_valid, 1);
    drain_seq(1024, 0, 1, bad);
    chk("R8 second group order", 32'(bad), 0);
    chk("R9 ended by group step", data_req, 0);
  endtask

  task automatic t_overrun();
    int bad;
    do_reset();
    start_write(8, 1'b0, 0);
    for (int k = 0; k < 512; k++)
      host_write(2'd2, 1'b0, {8'(4*k+3), 8'(4*k+2), 8'(4*k+1), 8'(4*k)});
    chk("R11 full without overrun", overrun, 0);
    host_write(2'd2, 1'b0, 32'hDEAD_BEEF);
    chk("R11 overrun set", overrun, 1);
    drain_seq(4, 0, 1, bad);
    chk("R11 old bytes kept", 32'(bad), 0);
    chk("R11 overrun sticky", overrun, 1);
    do_reset();
    chk("R1 reset clears overrun", overrun, 0);
  endtask

  initial begin
    t_reset();
    t_pack();
    t_same_cycle();
    t_read_sector();
    t_write_single();
    t_write_multi();
    t_overrun();
    finished = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule